// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Cycle Controller

This block sits between a clocked request port and a 16-bit asynchronous static RAM of 262,144 words. A requester presents a word address, write data, two byte enables and a direction flag under a valid/ready handshake. The controller then produces a full memory cycle on active-low chip-select, output-enable, write-enable and two byte-lane strobes, and it drives the address bus. Write data leaves on a separate output bus with its own driver enable. Read data comes back on a separate input bus, is masked per lane and is returned with a one-cycle valid strobe.

All memory timing is expressed as whole clock cycles. Four parameters give the address/data setup before the write strobes fall, the width of the write strobe overlap, the hold after the strobes rise, and the read access window. The integrator rounds the memory's nanosecond figures up to clock cycles for the chosen period. A write ends when the byte strobes rise. This lets a write that arrives in the last hold cycle keep write-enable low, so consecutive words are framed by the byte strobes alone.

Top module: `sramc_top`

## Requirements
- R1: After reset, and whenever no cycle is in progress, every memory strobe is high (inactive), the data driver is off, `reqReady` is high and `rspValid` is low.
- R2: A write holds chip-select and write-enable low, together with the strobe of each enabled lane, for exactly PULSE_CYC cycles. Enable bit 0 selects the lower lane (data bits 7:0, `memLbN`) and bit 1 selects the upper lane (bits 15:8, `memUbN`).
- R3: Around the strobe overlap, chip-select is low and the address and write data are driven and stable. This holds for SETUP_CYC cycles before the overlap with the lane strobes high, and for HOLD_CYC cycles after it.
- R4: A write with both enable bits clear lowers no lane strobe, so the memory contents are unchanged.
- R5: A read holds chip-select and output-enable low, write-enable high and the enabled lane strobes low for RD_CYC cycles. `rspValid` is high for exactly one cycle, in the cycle after the last access cycle.
- R6: The returned word carries the sampled memory data on enabled lanes and zero on lanes whose enable bit was clear.
- R7: The data driver is never on while output-enable is low. Output-enable is high in the cycle before write-enable falls.
- R8: A write accepted in the final hold cycle of a previous write keeps write-enable low between the two words. The second word's write begins and ends with its byte strobes, and both words are stored.
- R9: While write-enable is low, `reqReady` is offered only to a write. A read that follows a write is accepted only once the bus is idle.
- R10: Only one request is handled at a time: `reqReady` is low during setup, strobe, read access and every hold cycle but the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rspValid | output | 1 | One-cycle read data strobe |
| rspData | output | 16 | Masked read data |
| memCeN | output | 1 | Chip-select, active low |
| memOeN | output | 1 | Output-enable, active low |
| memWeN | output | 1 | Write-enable, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memAddr | output | 18 | Memory address bus |
| memDout | output | 16 | Write data towards the pad driver |
| memDin | input | 16 | Data from the pad receiver |
| memDoutEn | output | 1 | Pad driver enable |

## Verification
Counting from the negative edge after the accepting clock edge (cycle 0), a write shows setup in cycles 0 to SETUP_CYC-1. The strobe overlap follows for PULSE_CYC cycles, then hold for HOLD_CYC cycles, and the bus is idle in the next cycle. A read shows its access window in cycles 0 to RD_CYC-1, and `rspValid` with data is due in cycle RD_CYC and gone in RD_CYC+1. The bench samples every bus pin at each of those negative edges against the phase computed from the parameters. It uses non-default cycle counts so that each phase is longer than one cycle, and it confirms stored contents by reading back through a lane-accurate memory model.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSET,
    S_WPUL,
    S_WHLD,
    S_RACC
  } state_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture request fields
    logic ceAct;    // chip-select asserted
    logic oeAct;    // output-enable asserted
    logic weAct;    // write-enable asserted
    logic laneAct;  // byte strobes follow latched enables
    logic drive;    // write data driver on
    logic capture;  // sample read data this cycle
  } strobe_t;

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             chainWe;
  logic             cntDone;
  logic             lastHold;
  logic             accept;

  assign cntDone  = (cnt == '0);
  assign lastHold = (state == S_WHLD) && cntDone;
  assign reqReady = (state == S_IDLE) || (lastHold && reqWrite);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      chainWe <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            chainWe <= 1'b0;
            if (reqWrite) begin
              state <= S_WSET;
              cnt   <= SETUP_LD;
            end else begin
              state <= S_RACC;
              cnt   <= RD_LD;
            end
          end
        end
        S_WSET: begin
          if (cntDone) begin
            state <= S_WPUL;
            cnt   <= PULSE_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WPUL: begin
          if (cntDone) begin
            state <= S_WHLD;
            cnt   <= HOLD_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHLD: begin
          if (cntDone) begin
            if (accept) begin
              state   <= S_WSET;
              cnt     <= SETUP_LD;
              chainWe <= 1'b1;
            end else begin
              state   <= S_IDLE;
              chainWe <= 1'b0;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RACC: begin
          if (cntDone) begin
            state <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb      = '0;
    strb.load = accept;
    unique case (state)
      S_WSET: begin
        strb.ceAct = 1'b1;
        strb.weAct = chainWe;
        strb.drive = 1'b1;
      end
      S_WPUL: begin
        strb.ceAct   = 1'b1;
        strb.weAct   = 1'b1;
        strb.laneAct = 1'b1;
        strb.drive   = 1'b1;
      end
      S_WHLD: begin
        strb.ceAct = 1'b1;
        strb.weAct = 1'b1;
        strb.drive = 1'b1;
      end
      S_RACC: begin
        strb.ceAct   = 1'b1;
        strb.oeAct   = 1'b1;
        strb.laneAct = 1'b1;
        strb.capture = cntDone;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sramc_dp.sv
module sramc_dp
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  input  logic [DATA_W-1:0]     memDin,
  output logic                  memCeN,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic [DATA_W/8-1:0]   laneN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memDout,
  output logic                  memDoutEn,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspData
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdMask;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneN[g]           = !(strb.laneAct && beQ[g]);
    assign rdMask[g*8 +: 8]   = {8{beQ[g]}};
  end

  assign memCeN    = !strb.ceAct;
  assign memOeN    = !strb.oeAct;
  assign memWeN    = !strb.weAct;
  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign memDoutEn = strb.drive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      beQ      <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      rspValid <= strb.capture;
      if (strb.capture) begin
        rspData <= memDin & rdMask;
      end
    end
  end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoutEn
);

  strobe_t    strb;
  logic [1:0] laneN;

  sramc_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RD_CYC   (RD_CYC)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sramc_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqBe    (reqBe),
    .memDin   (memDin),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .laneN    (laneN),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int PULSE_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoutEn
);

  localparam logic [15:0] PULSE_L = 16'(PULSE_CYC);

  logic        ovl;
  logic [15:0] runLen;

  assign ovl = !memCeN && !memWeN && (!memUbN || !memLbN);

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (ovl) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R2: each strobe overlap lasts exactly PULSE_CYC cycles
  always_ff @(posedge clk) begin
    if (rstN && !ovl && runLen != 16'd0) begin
      p_pulse_len_r2: assert (runLen == PULSE_L)
        else $error("write overlap lasted %0d cycles", runLen);
    end
  end

  p_lane_needs_ce_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memUbN || !memLbN) |-> !memCeN);

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovl && $past(ovl)) |-> ($stable(memAddr) && $stable(memDout)));

  p_read_we_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN));

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(memDoutEn && !memOeN));

  p_oe_before_we_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memOeN) && memOeN));

  p_chain_write_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && reqReady) |-> reqWrite);

  p_busy_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memOeN) |-> !reqReady);

endmodule

bind sramc_top sramc_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PULSE_CYC(PULSE_CYC)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .reqWrite (reqWrite),
  .rspValid (rspValid),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memUbN   (memUbN),
  .memLbN   (memLbN),
  .memAddr  (memAddr),
  .memDout  (memDout),
  .memDoutEn(memDoutEn)
);

// File: tb/sramc_top_tb.sv
module sramc_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP_C = 2;
  localparam int PULSE_C = 3;
  localparam int HOLD_C  = 2;
  localparam int RD_C    = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        memCeN, memOeN, memWeN, memUbN, memLbN;
  logic [17:0] memAddr;
  logic [15:0] memDout;
  logic [15:0] memDin;
  logic        memDoutEn;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sramc_top #(
    .SETUP_CYC(SETUP_C),
    .PULSE_CYC(PULSE_C),
    .HOLD_CYC (HOLD_C),
    .RD_CYC   (RD_C)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memUbN(memUbN), .memLbN(memLbN), .memAddr(memAddr),
    .memDout(memDout), .memDin(memDin), .memDoutEn(memDoutEn)
  );

  // Lane-accurate memory model, indexed by the low address bits
  logic [15:0] mem [0:63];
  logic [15:0] expMem [0:63];

  assign memDin = (!memCeN && !memOeN && memWeN) ?
                  {(!memUbN ? mem[memAddr[5:0]][15:8] : 8'hC3),
                   (!memLbN ? mem[memAddr[5:0]][7:0]  : 8'h3C)} : 16'hDEAD;

  // Bus monitor
  logic prevWe = 1'b1, prevOe = 1'b1, prevOvl = 1'b0, weRose = 1'b1;
  int contention = 0, oeViol = 0, chained = 0;
  logic accWeN, accCeN;

  always @(negedge clk) begin
    if (rstN) begin
      logic ovl;
      ovl = !memCeN && !memWeN && (!memUbN || !memLbN);
      if (ovl) begin
        if (!memLbN) mem[memAddr[5:0]][7:0]  = memDout[7:0];
        if (!memUbN) mem[memAddr[5:0]][15:8] = memDout[15:8];
      end
      if (memDoutEn && !memOeN) contention++;
      if (prevWe && !memWeN && !prevOe) oeViol++;
      if (memWeN) weRose = 1'b1;
      if (ovl && !prevOvl) begin
        if (!weRose) chained++;
        weRose = 1'b0;
      end
      prevWe = memWeN;
      prevOe = memOeN;
      prevOvl = ovl;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] pat(input logic [17:0] a, input int k);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 + 32'(k) * 32'd4099;
    return t[15:0] ^ 16'h5A3C;
  endfunction

  // Presents a request and returns at the negedge after the accepting edge
  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqBe = be;
    forever begin
      #1;
      if (reqReady) begin
        accWeN = memWeN;
        accCeN = memCeN;
        @(posedge clk);
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [5:0] ctlVec();
    return {memCeN, memOeN, memWeN, memUbN, memLbN, memDoutEn};
  endfunction

  task automatic writeChk(input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be);
    issue(1'b1, a, d, be);
    reqValid = 1'b0;
    for (int n = 0; n <= SETUP_C + PULSE_C + HOLD_C; n++) begin
      logic [5:0] e;
      string r;
      if (n < SETUP_C) begin
        e = 6'b011111; r = "R3 setup";
      end else if (n < SETUP_C + PULSE_C) begin
        e = {3'b010, !be[1], !be[0], 1'b1};
        r = (be == 2'b00) ? "R4 no lane" : "R2 strobe";
      end else if (n < SETUP_C + PULSE_C + HOLD_C) begin
        e = 6'b010111; r = "R3 hold";
      end else begin
        e = 6'b111110; r = "R1 idle";
      end
      check(ctlVec() == e, r, 32'(ctlVec()), 32'(e));
      if (n < SETUP_C + PULSE_C + HOLD_C) begin
        check(memAddr == a && memDout == d, "R3 addr/data",
              {memAddr[15:0], memDout}, {a[15:0], d});
        if (n < SETUP_C + PULSE_C + HOLD_C - 1)
          check(!reqReady, "R10 busy", 32'(reqReady), 32'd0);
      end else begin
        check(reqReady, "R1 ready", 32'(reqReady), 32'd1);
      end
      @(negedge clk);
    end
    if (be[0]) expMem[a[5:0]][7:0]  = d[7:0];
    if (be[1]) expMem[a[5:0]][15:8] = d[15:8];
  endtask

  task automatic readChk(input logic [17:0] a, input logic [1:0] be);
    logic [15:0] ev;
    ev = expMem[a[5:0]] & {{8{be[1]}}, {8{be[0]}}};
    issue(1'b0, a, 16'h0, be);
    reqValid = 1'b0;
    for (int n = 0; n <= RD_C + 1; n++) begin
      if (n < RD_C) begin
        logic [5:0] e;
        e = {3'b001, !be[1], !be[0], 1'b0};
        check(ctlVec() == e && memAddr == a, "R5 read strobes",
              32'(ctlVec()), 32'(e));
        check(!reqReady && !rspValid, "R10 busy read",
              {reqReady, rspValid}, 32'd0);
      end else if (n == RD_C) begin
        check(rspValid, "R5 rsp due", 32'(rspValid), 32'd1);
        check(rspData == ev, "R6 read data", 32'(rspData), 32'(ev));
      end else begin
        check(!rspValid, "R5 rsp single", 32'(rspValid), 32'd0);
      end
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [17:0] addrs [5];
    addrs[0] = 18'h00000; addrs[1] = 18'h3FFFF; addrs[2] = 18'h20001;
    addrs[3] = 18'h15555; addrs[4] = 18'h0AAAA;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'h0;
      expMem[i] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctlVec() == 6'b111110 && reqReady && !rspValid, "R1 reset",
          {reqReady, rspValid, 24'h0, ctlVec()}, {1'b1, 1'b0, 24'h0, 6'b111110});

    // Full, lower-only, upper-only and empty writes over the address set
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 5; i++) begin
        logic [1:0] be;
        be = (k == 0) ? 2'b11 : (k == 1) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00;
        writeChk(addrs[i], pat(addrs[i], k), be);
      end
    end
    // Reads with every enable pattern (R6 masks clear lanes)
    for (int i = 0; i < 5; i++)
      for (int b = 0; b < 4; b++)
        readChk(addrs[i], 2'(b));

    // R8 back-to-back writes keep write-enable low
    begin
      int c0;
      c0 = chained;
      issue(1'b1, 18'h00123, 16'hBEEF, 2'b11);
      issue(1'b1, 18'h00124, 16'hCAFE, 2'b10);
      reqValid = 1'b0;
      repeat (SETUP_C + PULSE_C + HOLD_C + 4) @(negedge clk);
      expMem[6'h23] = 16'hBEEF;
      expMem[6'h24][15:8] = 8'hCA;
      check(chained == c0 + 1, "R8 chained word", 32'(chained), 32'(c0 + 1));
      readChk(18'h00123, 2'b11);
      readChk(18'h00124, 2'b11);
    end

    // R9 read behind a write waits for idle bus
    issue(1'b1, 18'h00030, 16'h1234, 2'b11);
    issue(1'b0, 18'h00030, 16'h0, 2'b11);
    reqValid = 1'b0;
    check(accWeN && accCeN, "R9 read accept idle", {accWeN, accCeN}, 32'd3);
    repeat (RD_C + 3) @(negedge clk);
    expMem[6'h30] = 16'h1234;
    readChk(18'h00030, 2'b01);

    check(contention == 0, "R7 driver vs oe", 32'(contention), 32'd0);
    check(oeViol == 0, "R7 oe before we", 32'(oeViol), 32'd0);
    summary();
    $finish;
  end

endmodule